// File: doc/BRIEF.md
# Source Operand Address Evaluator

This block decides where the source operand of an instruction comes from. It takes the 2-bit source addressing mode, the 4-bit source register number, a byte/word flag, the value of the named register, the instruction's extension word and the current program-counter value. From these it picks one of four operand origins: a register, a built-in constant, a memory read, or the extension word itself. It also returns the effective address, the constant value, whether an extension word and a memory read are needed, and how far the program counter and the source register must step.

The mode field is not read the same way for every register. With register 0 (the program counter), mode 01 becomes PC-relative and mode 11 becomes an immediate. With register 2, mode 01 becomes absolute addressing, and modes 10 and 11 produce the constants 4 and 8. Register 3 never touches memory: each of its four modes gives a fixed constant. All results are registered, so they appear one clock after the inputs are presented. The control sequencer that issues the memory cycles and updates the registers uses these results.

Top module: `src_operand_eval`

## Requirements
- R1: Mode 00 with any register other than 3 selects a register operand (`opnd_sel` = 00). In this case `need_ext` and `need_mem` are 0, both increments are 0, and `eff_addr` and `const_val` are 0.
- R2: Mode 01 with a register other than 0, 2 or 3 is indexed. `opnd_sel` = 10, `eff_addr` = `ext_word` + `reg_val` (modulo 2^16), `need_ext` = 1, `need_mem` = 1, `pc_incr` = 2 and `reg_incr` = 0.
- R3: Mode 01 with register 0 is PC-relative. The outputs are as in R2, except that `eff_addr` = `ext_word` + `pc_val` (modulo 2^16). Here `pc_val` is the address of the extension word.
- R4: Mode 01 with register 2 is absolute. The outputs are as in R2, except that `eff_addr` = `ext_word`.
- R5: Mode 10 with a register other than 2 or 3 is indirect. `opnd_sel` = 10, `eff_addr` = `reg_val`, `need_mem` = 1, `need_ext` = 0, and both increments are 0.
- R6: Mode 11 with a register other than 0, 2 or 3 is indirect with auto-increment. The outputs are as in R5, except that `reg_incr` is 1 when `byte_op` = 1 and 2 when `byte_op` = 0.
- R7: Mode 11 with register 0 is immediate. `opnd_sel` = 11 (the extension word is the operand), `eff_addr` = `pc_val`, `need_ext` = 1, `need_mem` = 0, `pc_incr` = 2 and `reg_incr` = 0.
- R8: Register 3 gives `opnd_sel` = 01 with `const_val` = 0, 1, 2 or 0xFFFF for modes 00, 01, 10 and 11. In all four cases there is no memory read, no extension word and no increment, and `eff_addr` = 0.
- R9: Register 2 in mode 10 gives constant 4, and in mode 11 gives constant 8. The other outputs are as in R8.
- R10: Every output is registered. It reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R11: Register 0 in modes 00 and 10, and register 2 in mode 00, behave as the ordinary register (R1) and indirect (R5) cases, using `reg_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_mode | input | 2 | Source addressing mode |
| src_reg | input | 4 | Source register number |
| byte_op | input | 1 | 1 for a byte operation, 0 for a word operation |
| reg_val | input | 16 | Current value of the named source register |
| ext_word | input | 16 | Extension word following the instruction |
| pc_val | input | 16 | Program counter, pointing at the extension word |
| opnd_sel | output | 2 | Operand origin: 00 register, 01 constant, 10 memory, 11 extension word |
| eff_addr | output | 16 | Effective memory address (the PC for an immediate) |
| const_val | output | 16 | Built-in constant value |
| need_ext | output | 1 | An extension word is consumed |
| need_mem | output | 1 | A memory read is required |
| reg_incr | output | 2 | Amount to add to the source register |
| pc_incr | output | 2 | Amount to add to the program counter |

## Verification
On every cycle, the assertions check a set of invariants. Constants never request memory, an extension word or a step. Any extension word always brings a program-counter step of 2. A register step only follows a mode-11 input. The absolute and PC-relative address sums are compared against the inputs of the previous cycle. The exact constant values, the indexed and indirect addresses, and the byte/word step size are only shown by the bench. The bench sweeps every mode and register pair with both operand sizes, adds address sums that wrap past 0xFFFF, and compares all outputs with a behavioural model one clock later. The reset values are also only shown by the bench.

// File: rtl/src_operand_eval.sv
module src_operand_eval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   src_mode,
  input  logic [3:0]   src_reg,
  input  logic         byte_op,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] ext_word,
  input  logic [W-1:0] pc_val,
  output logic [1:0]   opnd_sel,
  output logic [W-1:0] eff_addr,
  output logic [W-1:0] const_val,
  output logic         need_ext,
  output logic         need_mem,
  output logic [1:0]   reg_incr,
  output logic [1:0]   pc_incr
);
  localparam logic [1:0] SEL_REG = 2'b00, SEL_CON = 2'b01, SEL_MEM = 2'b10, SEL_EXT = 2'b11;

  wire is_pc  = (src_reg == 4'd0);
  wire is_sr  = (src_reg == 4'd2);
  wire is_cg  = (src_reg == 4'd3);
  wire [W-1:0] idx_base = is_pc ? pc_val : (is_sr ? '0 : reg_val);

  logic [1:0]   n_sel, n_ri, n_pi;
  logic [W-1:0] n_addr, n_con;
  logic         n_ext, n_mem;

  always_comb begin
    n_sel = SEL_REG; n_addr = '0; n_con = '0;
    n_ext = 1'b0; n_mem = 1'b0; n_ri = 2'd0; n_pi = 2'd0;
    case (src_mode)
      2'b00: if (is_cg) n_sel = SEL_CON;
      2'b01: if (is_cg) begin
               n_sel = SEL_CON; n_con = W'(1);
             end else begin
               n_sel = SEL_MEM; n_addr = ext_word + idx_base;
               n_ext = 1'b1; n_mem = 1'b1; n_pi = 2'd2;
             end
      2'b10: if (is_cg) begin
               n_sel = SEL_CON; n_con = W'(2);
             end else if (is_sr) begin
               n_sel = SEL_CON; n_con = W'(4);
             end else begin
               n_sel = SEL_MEM; n_addr = reg_val; n_mem = 1'b1;
             end
      default: if (is_cg) begin
               n_sel = SEL_CON; n_con = '1;
             end else if (is_sr) begin
               n_sel = SEL_CON; n_con = W'(8);
             end else if (is_pc) begin
               n_sel = SEL_EXT; n_addr = pc_val; n_ext = 1'b1; n_pi = 2'd2;
             end else begin
               n_sel = SEL_MEM; n_addr = reg_val; n_mem = 1'b1;
               n_ri = byte_op ? 2'd1 : 2'd2;
             end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_sel <= SEL_REG; eff_addr <= '0; const_val <= '0;
      need_ext <= 1'b0; need_mem <= 1'b0; reg_incr <= 2'd0; pc_incr <= 2'd0;
    end else begin
      opnd_sel <= n_sel; eff_addr <= n_addr; const_val <= n_con;
      need_ext <= n_ext; need_mem <= n_mem; reg_incr <= n_ri; pc_incr <= n_pi;
    end
  end

  p_ext_steps_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    need_ext |-> pc_incr == 2'd2);

  p_const_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_sel == SEL_CON |-> (!need_mem && !need_ext && reg_incr == 2'd0 && pc_incr == 2'd0));

  p_step_only_autoinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && reg_incr != 2'd0) |-> $past(src_mode) == 2'b11);

  p_absolute_zero_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(src_mode) == 2'b01 && $past(src_reg) == 4'd2)
      |-> eff_addr == $past(ext_word));

  p_symbolic_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(src_mode) == 2'b01 && $past(src_reg) == 4'd0)
      |-> eff_addr == W'($past(ext_word) + $past(pc_val)));
endmodule

// File: tb/tb_src_operand_eval.sv
module tb_src_operand_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_mode = '0;
  logic [3:0]  src_reg = '0;
  logic        byte_op = 1'b0;
  logic [15:0] reg_val = '0, ext_word = '0, pc_val = '0;
  logic [1:0]  opnd_sel, reg_incr, pc_incr;
  logic [15:0] eff_addr, const_val;
  logic        need_ext, need_mem;

  int checks = 0, errors = 0;
  bit have_exp = 0;
  logic [57:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  src_operand_eval dut (.clk, .rst_n, .src_mode, .src_reg, .byte_op, .reg_val,
    .ext_word, .pc_val, .opnd_sel, .eff_addr, .const_val, .need_ext,
    .need_mem, .reg_incr, .pc_incr);

  // packed: sel(2) addr(16) con(16) ext mem ri(2) pi(2) + pad
  function automatic logic [57:0] model(input int m, input int r, input bit b,
      input int rv, input int ew, input int pc, output string tag);
    int sel = 0, addr = 0, con = 0, ext = 0, mem = 0, ri = 0, pi = 0;
    if (r == 3) begin
      sel = 1; tag = "R8";
      con = (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 2 : 16'hFFFF;
    end else if (r == 2 && m >= 2) begin
      sel = 1; tag = "R9"; con = (m == 2) ? 4 : 8;
    end else if (m == 0) begin
      tag = (r == 0 || r == 2) ? "R11" : "R1";
    end else if (m == 1) begin
      sel = 2; ext = 1; mem = 1; pi = 2;
      if (r == 0) begin addr = ew + pc; tag = "R3"; end
      else if (r == 2) begin addr = ew; tag = "R4"; end
      else begin addr = ew + rv; tag = "R2"; end
    end else if (m == 2) begin
      sel = 2; mem = 1; addr = rv; tag = (r == 0) ? "R11" : "R5";
    end else if (r == 0) begin
      sel = 3; ext = 1; pi = 2; addr = pc; tag = "R7";
    end else begin
      sel = 2; mem = 1; addr = rv; ri = b ? 1 : 2; tag = "R6";
    end
    return {16'd0, sel[1:0], addr[15:0], con[15:0], ext[0], mem[0], ri[1:0], pi[1:0]};
  endfunction

  function automatic logic [57:0] actual();
    return {16'd0, opnd_sel, eff_addr, const_val, need_ext, need_mem, reg_incr, pc_incr};
  endfunction

  task automatic check(input string tag, input logic [57:0] exp);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  // at each negedge: compare previous cycle's prediction, then drive new inputs
  task automatic step(input int m, input int r, input bit b, input int rv,
                      input int ew, input int pc);
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
    src_mode = 2'(m); src_reg = 4'(r); byte_op = b;
    reg_val = 16'(rv); ext_word = 16'(ew); pc_val = 16'(pc);
    exp_q.push_back(model(m, r, b, rv, ew, pc, t));
    tag_q.push_back(t);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        src_mode = 2'b01; src_reg = 4'd5; ext_word = 16'h1234;
        repeat (3) @(negedge clk);
        check("R10 reset", 58'd0);
        check("R10 reset", 58'd0);
        rst_n = 1'b1;
        // full sweep, both sizes
        for (int b = 0; b < 2; b++)
          for (int m = 0; m < 4; m++)
            for (int r = 0; r < 16; r++)
              step(m, r, b[0], 16'h1000 + r * 16'h111, 16'h0040 + m, 16'h8002 + r * 2);
        // wrapping sums R2 R3
        step(1, 7, 0, 16'hFFF0, 16'h0020, 16'h0);
        step(1, 0, 0, 16'h0, 16'hFFFE, 16'h0010);
        step(1, 2, 1, 16'hABCD, 16'hFFFF, 16'h1234);
        // back-to-back changes R6 R7 R10
        step(3, 4, 1, 16'h0201, 0, 16'h8000);
        step(3, 4, 0, 16'h0201, 0, 16'h8000);
        step(3, 0, 1, 16'h5555, 16'h7777, 16'hC018);
        for (int i = 0; i < 40; i++)
          step(i % 4, (i * 7) % 16, i[0], i * 16'h0F13, i * 16'h3A01, i * 16'h0102);
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
        // R10 reset clears
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clear", 58'd0);
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule